// File: doc/BRIEF.md
# Reloading down-count timer unit

A small register-mapped timer block with `NCH` independent 32-bit channels. Each channel has a down-counter, a reload-value register and a control register. A shared start register runs or stops each channel. A per-channel prescaler divides the module clock by 4, 16, 64 or 256. The counter steps down once on each prescaled tick. A tick taken while the counter is zero is an underflow. An underflow loads the counter from the reload register, sets a sticky underflow flag and, if that is enabled, asserts the channel's interrupt line.

Software sets up a periodic timer by writing the interval into both the counter and the reload register. A reload value of zero gives near one-shot behaviour. Loading all ones into both registers gives a free-running wrap-around time base. The bus port is a single-cycle write port: a write lands on the clock edge where `req_i` and `we_i` are high. Read data is driven combinationally from `addr_i`.

Top module: `tmr_unit`

## Requirements
- R1: After reset the start register reads 0, every counter and reload register reads 0, every control register reads 0x0020 and every interrupt output is low.
- R2: Word address 0 is the start register, and bit i runs channel i. Bits at or above NCH are not stored and read 0. A stopped channel holds its count and never ticks.
- R3: Control bits [2:0] select the tick rate: select s divides the module clock by 4 << (2*s), and selects 4 to 7 divide by 256. A channel started on clock edge 0 takes its first tick on edge DIV.
- R4: Channel i sits at word base 4*(i+1): +0 reload, +1 counter, +2 control. Each tick decrements a nonzero count by one. A tick at count 0 is an underflow, and it loads the reload value.
- R5: An underflow sets control bit 8, the underflow flag. The flag stays set until software clears it.
- R6: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag unchanged.
- R7: An underflow in the same cycle as a clearing control write leaves the flag set.
- R8: Control bit 5 is the interrupt enable. Interrupt output i is high exactly when channel i's flag and enable are both 1.
- R9: A counter write takes effect on its own clock edge, whether the channel is running or stopped, and it overrides a tick on that edge.
- R10: With reload 0 the counter stays at 0 after its first underflow, and every later tick sets the flag again. With reload all ones the counter wraps from 0 to 0xFFFFFFFF and keeps counting down.
- R11: Channels count independently, each at its own prescale rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | NCH | Per-channel underflow interrupt |

## Verification
The bench goes after the exact edge of the first tick and of the underflow, sampling one cycle before and one cycle on. An off-by-one prescaler or counter would show the wrong count at one of those points. It also lands a flag clear on the same edge as an underflow: a design that lets the clear win loses that event. Other cases are a write of 1 to the flag, which a naive design would use to set or toggle it, and select code 7, which a design that shifts without clamping would mis-divide. Zero and all-ones reload values are exercised as well. A wrong wrap would either hold the counter or fail to re-flag on later ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned CTL_W   = 16;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned IE_BIT  = 5;
  localparam int unsigned UNF_BIT = 8;
  localparam int unsigned PRE_W   = 8;
  localparam int unsigned RUN_W   = 8;
  localparam logic [CTL_W-1:0] CTL_RST = 16'h0020;

  typedef enum logic [1:0] {
    REG_RLD = 2'd0,
    REG_CNT = 2'd1,
    REG_CTL = 2'd2
  } ch_reg_e;

  // terminal prescale count: 4 << (2*sel) - 1, sel >= 3 saturates at /256
  function automatic logic [PRE_W-1:0] pre_last(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] r;
    case (sel)
      3'd0:    r = 8'd3;
      3'd1:    r = 8'd15;
      3'd2:    r = 8'd63;
      default: r = 8'd255;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;

  assign last   = pre_last(sel_i);
  // >= so a select change mid-period cannot strand the counter past its limit
  assign tick_o = run_i && (pre_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!run_i)  pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_rld_i,
  input  logic             wr_cnt_i,
  input  logic             wr_ctl_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rld_o,
  output logic [DW-1:0]    cnt_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             flag_o,
  output logic             ie_o,
  output logic             irq_o
);
  logic [DW-1:0]    rld_q, cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, flag_q, unf, sw_clr;

  assign unf    = tick_i && (cnt_q == '0);
  assign sw_clr = wr_ctl_i && !wdata_i[UNF_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rld_q <= '0;
    else if (wr_rld_i) rld_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_cnt_i) cnt_q <= wdata_i;
    else if (unf)      cnt_q <= rld_q;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= CTL_RST[SEL_W-1:0];
      ie_q  <= CTL_RST[IE_BIT];
    end else if (wr_ctl_i) begin
      sel_q <= wdata_i[SEL_W-1:0];
      ie_q  <= wdata_i[IE_BIT];
    end
  end

  // hardware set outranks a software clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= CTL_RST[UNF_BIT];
    else if (unf)    flag_q <= 1'b1;
    else if (sw_clr) flag_q <= 1'b0;
  end

  always_comb begin
    ctl_o              = '0;
    ctl_o[SEL_W-1:0]   = sel_q;
    ctl_o[IE_BIT]      = ie_q;
    ctl_o[UNF_BIT]     = flag_q;
  end

  assign rld_o  = rld_q;
  assign cnt_o  = cnt_q;
  assign sel_o  = sel_q;
  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign irq_o  = flag_q & ie_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH-1:0]    irq_o
);
  localparam logic [RUN_W-1:0] RUN_MASK = RUN_W'((1 << NCH) - 1);

  logic                       wr;
  logic [RUN_W-1:0]           run_q;
  logic [NCH-1:0]             run_w, tick_w, wr_rld_w, wr_cnt_w, wr_ctl_w;
  logic [NCH-1:0]             flag_w, ie_w;
  logic [NCH-1:0][DW-1:0]     rld_w, cnt_w;
  logic [NCH-1:0][CTL_W-1:0]  ctl_w;
  logic [NCH-1:0][SEL_W-1:0]  sel_w;

  assign wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (wr && addr_i == '0) run_q <= wdata_i[RUN_W-1:0] & RUN_MASK;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned BASE = 4 * (c + 1);

    assign run_w[c]    = run_q[c];
    assign wr_rld_w[c] = wr && (addr_i == ADDR_W'(BASE + int'(REG_RLD)));
    assign wr_cnt_w[c] = wr && (addr_i == ADDR_W'(BASE + int'(REG_CNT)));
    assign wr_ctl_w[c] = wr && (addr_i == ADDR_W'(BASE + int'(REG_CTL)));

    tmr_prescaler i_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_w[c]),
      .sel_i  (sel_w[c]),
      .tick_o (tick_w[c])
    );

    tmr_channel i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_w[c]),
      .wr_rld_i (wr_rld_w[c]),
      .wr_cnt_i (wr_cnt_w[c]),
      .wr_ctl_i (wr_ctl_w[c]),
      .wdata_i  (wdata_i),
      .rld_o    (rld_w[c]),
      .cnt_o    (cnt_w[c]),
      .ctl_o    (ctl_w[c]),
      .sel_o    (sel_w[c]),
      .flag_o   (flag_w[c]),
      .ie_o     (ie_w[c]),
      .irq_o    (irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o[RUN_W-1:0] = run_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == ADDR_W'(4 * c + 4 + int'(REG_RLD))) rdata_o = rld_w[c];
      if (addr_i == ADDR_W'(4 * c + 4 + int'(REG_CNT))) rdata_o = cnt_w[c];
      if (addr_i == ADDR_W'(4 * c + 4 + int'(REG_CTL))) rdata_o = DW'(ctl_w[c]);
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NCH-1:0]            run_w,
  input logic [NCH-1:0]            tick_w,
  input logic [NCH-1:0]            wr_cnt_w,
  input logic [NCH-1:0]            wr_ctl_w,
  input logic [NCH-1:0]            flag_w,
  input logic [NCH-1:0]            ie_w,
  input logic [NCH-1:0][DW-1:0]    cnt_w,
  input logic [NCH-1:0][DW-1:0]    rld_w,
  input logic [DW-1:0]             wdata_i,
  input logic [NCH-1:0]            irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    p_tick_needs_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_w[c] |-> run_w[c]);

    p_hold_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_w[c] && !wr_cnt_w[c]) |=> $stable(cnt_w[c]));

    p_decrement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_w[c] && cnt_w[c] != '0 && !wr_cnt_w[c]) |=> cnt_w[c] == $past(cnt_w[c]) - 1);

    p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_w[c] && cnt_w[c] == '0 && !wr_cnt_w[c]) |=> cnt_w[c] == $past(rld_w[c]));

    p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_w[c] && cnt_w[c] == '0) |=> flag_w[c]);

    p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_w[c] && !wr_ctl_w[c]) |=> flag_w[c]);

    p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (flag_w[c] && ie_w[c]));

    p_cnt_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cnt_w[c] |=> cnt_w[c] == $past(wdata_i));
  end
endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH)) i_tmr_unit_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_w    (run_w),
  .tick_w   (tick_w),
  .wr_cnt_w (wr_cnt_w),
  .wr_ctl_w (wr_ctl_w),
  .flag_w   (flag_w),
  .ie_w     (ie_w),
  .cnt_w    (cnt_w),
  .rld_w    (rld_w),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o)
);

// File: tb/test_tmr_unit.sv
`timescale 1ns/1ps
module test_tmr_unit;
  localparam int unsigned NCH    = 2;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_RUN = 6'd0;
  localparam logic [ADDR_W-1:0] A0_RLD = 6'd4, A0_CNT = 6'd5, A0_CTL = 6'd6;
  localparam logic [ADDR_W-1:0] A1_RLD = 6'd8, A1_CNT = 6'd9, A1_CTL = 6'd10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH-1:0]    irq;
  int                nvec = 0, nerr = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  tmr_unit #(.NCH(NCH), .ADDR_W(ADDR_W)) i_tmr_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge, returns at the following negedge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_RUN, d);  chk("R1 start reg", d, 32'h0);
    rd(A0_CTL, d); chk("R1 ctl0", d, 32'h20);
    rd(A1_CTL, d); chk("R1 ctl1", d, 32'h20);
    rd(A0_CNT, d); chk("R1 cnt0", d, 32'h0);
    rd(A1_RLD, d); chk("R1 rld1", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr(A0_RLD, 32'd3); wr(A0_CNT, 32'd3); wr(A0_CTL, 32'h20);
    wr(A_RUN, 32'h1);                  // run at P0, ticks every 4
    step(3);  rd(A0_CNT, d); chk("R3 no tick before edge 4", d, 32'd3);
    step(1);  rd(A0_CNT, d); chk("R3 first tick at edge 4", d, 32'd2);
    step(11); rd(A0_CNT, d); chk("R4 count at zero", d, 32'd0);
    rd(A0_CTL, d); chk("R5 flag clear pre-underflow", d, 32'h20);
    step(1);  rd(A0_CNT, d); chk("R4 reload on underflow", d, 32'd3);
    rd(A0_CTL, d); chk("R5 flag set", d, 32'h120);
    chk("R8 irq0 raised", 32'(irq), 32'h1);
    step(8);  rd(A0_CTL, d); chk("R5 flag sticky", d, 32'h120);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(A_RUN, 32'h0);
    wr(A0_CTL, 32'h120); rd(A0_CTL, d); chk("R6 write 1 keeps flag", d, 32'h120);
    wr(A0_CTL, 32'h020); rd(A0_CTL, d); chk("R6 write 0 clears flag", d, 32'h20);
    chk("R8 irq0 dropped", 32'(irq), 32'h0);
  endtask

  task automatic t_stop_hold;
    logic [31:0] a, b;
    wr(A0_CNT, 32'd9);
    rd(A0_CNT, a); step(50); rd(A0_CNT, b);
    chk("R2 stopped channel holds", b, a);
    wr(A_RUN, 32'hFF); rd(A_RUN, a); chk("R2 upper start bits read 0", a, 32'h3);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(A0_CTL, 32'h2); wr(A0_CNT, 32'd1); wr(A_RUN, 32'h1);
    step(63); rd(A0_CNT, d); chk("R3 /64 before", d, 32'd1);
    step(1);  rd(A0_CNT, d); chk("R3 /64 at edge", d, 32'd0);
    wr(A_RUN, 32'h0);
    wr(A0_CTL, 32'h7); wr(A0_CNT, 32'd1); wr(A_RUN, 32'h1);
    step(255); rd(A0_CNT, d); chk("R3 sel7 /256 before", d, 32'd1);
    step(1);   rd(A0_CNT, d); chk("R3 sel7 /256 at edge", d, 32'd0);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    wr(A0_RLD, 32'd5); wr(A0_CNT, 32'd0); wr(A0_CTL, 32'h20);
    wr(A_RUN, 32'h1);
    step(3);
    wr(A0_CTL, 32'h020);               // lands on edge 4, same as underflow
    rd(A0_CTL, d); chk("R7 set beats clear", d, 32'h120);
    rd(A0_CNT, d); chk("R4 reload 5", d, 32'd5);
    wr(A0_CNT, 32'h1234); rd(A0_CNT, d); chk("R9 write while running", d, 32'h1234);
    wr(A_RUN, 32'h0);
    wr(A0_CNT, 32'h77); rd(A0_CNT, d); chk("R9 write while stopped", d, 32'h77);
    wr(A0_CTL, 32'h20);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    wr(A1_RLD, 32'd0); wr(A1_CNT, 32'd2); wr(A1_CTL, 32'h0);
    wr(A_RUN, 32'h2);
    step(11); rd(A1_CTL, d); chk("R10 no flag before underflow", d, 32'h0);
    step(1);  rd(A1_CTL, d); chk("R10 flag on underflow", d, 32'h100);
    rd(A1_CNT, d); chk("R10 zero reload stays 0", d, 32'd0);
    chk("R8 irq1 masked", 32'(irq), 32'h0);
    wr(A1_CTL, 32'h0);                  // lands edge 13
    step(2);  rd(A1_CTL, d); chk("R10 cleared", d, 32'h0);
    step(1);  rd(A1_CTL, d); chk("R10 re-flag next tick", d, 32'h100);
    wr(A_RUN, 32'h0);
    wr(A1_RLD, 32'hFFFF_FFFF); wr(A1_CNT, 32'd0); wr(A1_CTL, 32'h0);
    wr(A_RUN, 32'h2);
    step(4); rd(A1_CNT, d); chk("R10 wrap to all ones", d, 32'hFFFF_FFFF);
    step(4); rd(A1_CNT, d); chk("R10 keeps counting", d, 32'hFFFF_FFFE);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_indep;
    logic [31:0] d;
    wr(A0_CTL, 32'h0); wr(A0_CNT, 32'd100);
    wr(A1_CTL, 32'h1); wr(A1_CNT, 32'd100);
    wr(A_RUN, 32'h3);
    step(40);
    rd(A0_CNT, d); chk("R11 ch0 /4", d, 32'd90);
    rd(A1_CNT, d); chk("R11 ch1 /16", d, 32'd98);
    wr(A_RUN, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_clear();
    t_stop_hold();
    t_prescale();
    t_simul();
    t_oneshot();
    t_indep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule